// File: doc/BRIEF.md
# DAC Streaming Core Control Register Bank

This block is the software-facing register file of a multi-channel DAC streaming core. Software reaches it through 32-bit words on a 4-byte stride, using separate single-cycle read and write strobes. From those words the block drives the core's reset, the reset of its clock manager and a clock-enable control. It also generates a one-cycle channel synchronisation strobe and holds a routing mode bit. Per-channel tone and source settings sit in a window that repeats once per channel.

Power-up follows a fixed order. The bank starts with every reset output asserted. Software releases the clock-manager reset and polls a status word until the clock manager reports lock. It then releases the core reset. The block enforces that order in hardware: the core reset output stays asserted for as long as the lock input is low. Every register stays readable and writable while the core is held in reset. A read-only word tells software whether the tone generator was built into the core.

Top module: `dac_ctrl_regs`

## Requirements
- R1: After reset, the following are all zero: every register, `core_rst_n`, `clkmgr_rst_n`, `ce_n`, `indep_route`, `sync_pulse`, every per-channel output and `rd_data`.
- R2: Bits 2:0 of the word at 0x040 read back as written and all other bits read 0. Bit 1 drives `clkmgr_rst_n` and bit 2 drives `ce_n`. A write takes effect at the clock edge that accepts it.
- R3: `core_rst_n` is high only when bit 0 and bit 1 of the word at 0x040 are both set and `clk_lock` is high. It falls in the same cycle that `clk_lock` falls.
- R4: A write to 0x044 with bit 0 set raises `sync_pulse` for exactly the one cycle that follows the accepting edge. A write to 0x044 with bit 0 clear raises no pulse. A read of 0x044 returns 0.
- R5: Bit 4 of the word at 0x048 is stored and drives `indep_route`, where 1 means independent per-channel routing and 0 means grouped. All other bits of 0x048 read 0.
- R6: A read of 0x074 returns the value of `clk_lock` in bit 17, sampled in the read cycle, and 0 in every other bit.
- R7: A read of 0x00C returns the parameter `TONE_ABSENT` in bit 6 and 0 in every other bit. Writes to 0x00C have no effect.
- R8: Channel c (c < NUM_CH) occupies 0x400 + c*0x40. Offset 0x00 holds the tone A scale (bits 15:0) and offset 0x08 the tone B scale (bits 15:0). Offsets 0x04 and 0x0C hold the full 32-bit tone A and tone B words (phase in 31:16, frequency in 15:0). Offset 0x18 holds the source select (bits 3:0). Each field appears on the output bus at slice c and reads back zero-extended.
- R9: Every other address reads 0 and ignores writes. This covers slots at or above NUM_CH, unlisted offsets, addresses not word aligned, anything outside the listed words and everything from 0x800 up.
- R10: After 0x000 is written to 0x040, `core_rst_n` and `clkmgr_rst_n` are low. Every other register can still be written and read back.
- R11: `rd_data` takes the addressed value at the edge where `rd_en` is high and holds it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of read |
| rd_data | output | 32 | Registered read data |
| clk_lock | input | 1 | Clock manager lock indication |
| core_rst_n | output | 1 | Core active-low reset, gated by lock |
| clkmgr_rst_n | output | 1 | Clock manager active-low reset |
| ce_n | output | 1 | Active-low clock-enable control |
| sync_pulse | output | 1 | One-cycle channel sync strobe |
| indep_route | output | 1 | 1 = independent per-channel routing |
| ch_scale_a | output | NUM_CH*SCALE_W | Tone A scale per channel |
| ch_scale_b | output | NUM_CH*SCALE_W | Tone B scale per channel |
| ch_tone_a | output | NUM_CH*32 | Tone A phase/frequency per channel |
| ch_tone_b | output | NUM_CH*32 | Tone B phase/frequency per channel |
| ch_src | output | NUM_CH*SEL_W | Source select per channel |

## Verification
A wrong decode of a channel slot or offset shows up one cycle after the write, as a changed slice on a per-channel bus that software never addressed. It also appears on the next readback of that address. A lost lock gate or a stale reset bit shows on `core_rst_n` within the same cycle as the lock change, or one edge after the write. A sync strobe that sticks or doubles shows on `sync_pulse` in the second cycle after the write.

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs #(
  parameter int ADDR_W      = 12,
  parameter int NUM_CH      = 4,
  parameter int SCALE_W     = 16,
  parameter int SEL_W       = 4,
  parameter bit TONE_ABSENT = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [31:0]                rd_data,
  input  logic                       clk_lock,
  output logic                       core_rst_n,
  output logic                       clkmgr_rst_n,
  output logic                       ce_n,
  output logic                       sync_pulse,
  output logic                       indep_route,
  output logic [NUM_CH*SCALE_W-1:0]  ch_scale_a,
  output logic [NUM_CH*SCALE_W-1:0]  ch_scale_b,
  output logic [NUM_CH*32-1:0]       ch_tone_a,
  output logic [NUM_CH*32-1:0]       ch_tone_b,
  output logic [NUM_CH*SEL_W-1:0]    ch_src
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(12'h040);
  localparam logic [ADDR_W-1:0] A_SYNC = ADDR_W'(12'h044);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(12'h048);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h074);
  localparam logic [5:0] O_SCA = 6'h00;
  localparam logic [5:0] O_TNA = 6'h04;
  localparam logic [5:0] O_SCB = 6'h08;
  localparam logic [5:0] O_TNB = 6'h0C;
  localparam logic [5:0] O_SRC = 6'h18;

  logic [2:0]  rst_q;
  logic        mode_q;
  logic        sync_q;
  logic [31:0] rd_q;
  logic [31:0] rd_next;
  logic [NUM_CH*32-1:0] ch_rd;

  wire       wr_win  = (wr_addr >> 10) == ADDR_W'(1);
  wire       rd_win  = (rd_addr >> 10) == ADDR_W'(1);
  wire [3:0] wr_slot = wr_addr[9:6];
  wire [3:0] rd_slot = rd_addr[9:6];
  wire [5:0] wr_off  = wr_addr[5:0];
  wire [5:0] rd_off  = rd_addr[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= '0;
      mode_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= wr_en && wr_addr == A_SYNC && wr_data[0];
      if (wr_en && wr_addr == A_RST)  rst_q  <= wr_data[2:0];
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data[4];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [SCALE_W-1:0] sca_q, scb_q;
    logic [31:0]        tna_q, tnb_q;
    logic [SEL_W-1:0]   src_q;
    wire hit = wr_en && wr_win && wr_slot == 4'(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sca_q <= '0;
        scb_q <= '0;
        tna_q <= '0;
        tnb_q <= '0;
        src_q <= '0;
      end else if (hit) begin
        case (wr_off)
          O_SCA:   sca_q <= wr_data[SCALE_W-1:0];
          O_SCB:   scb_q <= wr_data[SCALE_W-1:0];
          O_TNA:   tna_q <= wr_data;
          O_TNB:   tnb_q <= wr_data;
          O_SRC:   src_q <= wr_data[SEL_W-1:0];
          default: ;
        endcase
      end
    end

    assign ch_rd[g*32 +: 32] =
        (rd_off == O_SCA) ? {{(32-SCALE_W){1'b0}}, sca_q} :
        (rd_off == O_SCB) ? {{(32-SCALE_W){1'b0}}, scb_q} :
        (rd_off == O_TNA) ? tna_q :
        (rd_off == O_TNB) ? tnb_q :
        (rd_off == O_SRC) ? {{(32-SEL_W){1'b0}}, src_q} : 32'h0;

    assign ch_scale_a[g*SCALE_W +: SCALE_W] = sca_q;
    assign ch_scale_b[g*SCALE_W +: SCALE_W] = scb_q;
    assign ch_tone_a[g*32 +: 32]            = tna_q;
    assign ch_tone_b[g*32 +: 32]            = tnb_q;
    assign ch_src[g*SEL_W +: SEL_W]         = src_q;
  end

  always_comb begin
    rd_next = '0;
    unique case (rd_addr)
      A_CFG:   rd_next[6]   = TONE_ABSENT;
      A_RST:   rd_next[2:0] = rst_q;
      A_MODE:  rd_next[4]   = mode_q;
      A_STAT:  rd_next[17]  = clk_lock;
      default: begin
        for (int c = 0; c < NUM_CH; c++)
          if (rd_win && rd_slot == 4'(c)) rd_next = ch_rd[c*32 +: 32];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data      = rd_q;
  assign core_rst_n   = rst_q[0] & rst_q[1] & clk_lock;
  assign clkmgr_rst_n = rst_q[1];
  assign ce_n         = rst_q[2];
  assign sync_pulse   = sync_q;
  assign indep_route  = mode_q;

endmodule

// File: rtl/dac_ctrl_regs_chk.sv
module dac_ctrl_regs_chk #(
  parameter int ADDR_W      = 12,
  parameter bit TONE_ABSENT = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_bit0,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              clk_lock,
  input logic              core_rst_n,
  input logic              clkmgr_rst_n,
  input logic              sync_pulse
);

  assert_lock_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_lock |-> !core_rst_n);

  assert_core_after_clkmgr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |-> clkmgr_rst_n);

  assert_sync_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> ($past(wr_en) && $past(wr_addr) == ADDR_W'(12'h044) && $past(wr_bit0)));

  assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(12'h074)) |=> rd_data == {14'b0, $past(clk_lock), 17'b0});

  assert_config_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(12'h00C)) |=> rd_data == {25'b0, TONE_ABSENT, 6'b0});

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind dac_ctrl_regs dac_ctrl_regs_chk #(.ADDR_W(ADDR_W), .TONE_ABSENT(TONE_ABSENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit0(wr_data[0]),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .clk_lock(clk_lock),
  .core_rst_n(core_rst_n), .clkmgr_rst_n(clkmgr_rst_n), .sync_pulse(sync_pulse)
);

// File: tb/dac_ctrl_regs_bench.sv
module dac_ctrl_regs_bench;
  localparam int AW = 12, NCH = 4, SW = 16, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, clk_lock = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic core_rst_n, clkmgr_rst_n, ce_n, sync_pulse, indep_route;
  logic [NCH*SW-1:0] ch_scale_a, ch_scale_b;
  logic [NCH*32-1:0] ch_tone_a, ch_tone_b;
  logic [NCH*LW-1:0] ch_src;

  int total = 0, bad = 0;
  bit done = 0;

  logic [SW-1:0] m_sca [NCH];
  logic [SW-1:0] m_scb [NCH];
  logic [31:0]   m_tna [NCH];
  logic [31:0]   m_tnb [NCH];
  logic [LW-1:0] m_src [NCH];

  always #4 clk = ~clk;

  dac_ctrl_regs #(.ADDR_W(AW), .NUM_CH(NCH), .SCALE_W(SW), .SEL_W(LW), .TONE_ABSENT(1'b1)) u_dac_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .clk_lock(clk_lock),
    .core_rst_n(core_rst_n), .clkmgr_rst_n(clkmgr_rst_n), .ce_n(ce_n),
    .sync_pulse(sync_pulse), .indep_route(indep_route),
    .ch_scale_a(ch_scale_a), .ch_scale_b(ch_scale_b),
    .ch_tone_a(ch_tone_a), .ch_tone_b(ch_tone_b), .ch_src(ch_src));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    int c;
    if (a[11:10] != 2'b01) return 32'h0;
    c = int'(a[9:6]);
    if (c >= NCH) return 32'h0;
    case (a[5:0])
      6'h00: return {16'h0, m_sca[c]};
      6'h08: return {16'h0, m_scb[c]};
      6'h04: return m_tna[c];
      6'h0C: return m_tnb[c];
      6'h18: return {28'h0, m_src[c]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d);
    int c;
    if (a[11:10] != 2'b01) return;
    c = int'(a[9:6]);
    if (c >= NCH) return;
    case (a[5:0])
      6'h00: m_sca[c] = d[15:0];
      6'h08: m_scb[c] = d[15:0];
      6'h04: m_tna[c] = d;
      6'h0C: m_tnb[c] = d;
      6'h18: m_src[c] = d[3:0];
      default: ;
    endcase
  endfunction

  task automatic check_outs(input string req);
    for (int c = 0; c < NCH; c++) begin
      check(req, {16'h0, ch_scale_a[c*SW +: SW]}, {16'h0, m_sca[c]});
      check(req, {16'h0, ch_scale_b[c*SW +: SW]}, {16'h0, m_scb[c]});
      check(req, ch_tone_a[c*32 +: 32], m_tna[c]);
      check(req, ch_tone_b[c*32 +: 32], m_tnb[c]);
      check(req, {28'h0, ch_src[c*LW +: LW]}, {28'h0, m_src[c]});
    end
  endtask

  function automatic logic [AW-1:0] rand_addr();
    logic [AW-1:0] a;
    int k = $urandom % 8;
    if (k < 6) begin
      logic [5:0] off;
      case ($urandom % 7)
        0: off = 6'h00; 1: off = 6'h04; 2: off = 6'h08;
        3: off = 6'h0C; 4: off = 6'h18;
        default: off = 6'($urandom);
      endcase
      a = {2'b01, 4'($urandom % 16), off};
    end else begin
      a = 12'($urandom);
      if (a[11:10] != 2'b01 && (a == 12'h00C || a == 12'h040 || a == 12'h044 ||
                                a == 12'h048 || a == 12'h074)) a = 12'h010;
    end
    return a;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED));
    for (int c = 0; c < NCH; c++) begin
      m_sca[c] = 0; m_scb[c] = 0; m_tna[c] = 0; m_tnb[c] = 0; m_src[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 core_rst_n", {31'h0, core_rst_n}, 0);
    check("R1 clkmgr_rst_n", {31'h0, clkmgr_rst_n}, 0);
    check("R1 ce_n", {31'h0, ce_n}, 0);
    check("R1 sync", {31'h0, sync_pulse}, 0);
    check("R1 route", {31'h0, indep_route}, 0);
    check("R1 rd_data", rd_data, 0);
    check_outs("R1 channel outs");
    rd(12'h040, r); check("R1 reset word", r, 0);

    // R7 config word read-only
    rd(12'h00C, r); check("R7 config", r, 32'h40);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, r); check("R7 config after write", r, 32'h40);

    // R2/R3/R6 bring-up sequence
    wr(12'h040, 32'h2);
    check("R2 clkmgr released", {31'h0, clkmgr_rst_n}, 1);
    check("R3 core held, no lock", {31'h0, core_rst_n}, 0);
    rd(12'h074, r); check("R6 status unlocked", r, 0);
    @(negedge clk); clk_lock = 1;
    rd(12'h074, r); check("R6 status locked", r, 32'h0002_0000);
    check("R3 core held, bit0 clear", {31'h0, core_rst_n}, 0);
    wr(12'h040, 32'h3);
    check("R3 core released", {31'h0, core_rst_n}, 1);
    @(negedge clk); clk_lock = 0; #1;
    check("R3 core on lock loss", {31'h0, core_rst_n}, 0);
    @(negedge clk); clk_lock = 1; #1;
    check("R3 core on relock", {31'h0, core_rst_n}, 1);
    wr(12'h040, 32'h1);
    check("R3 core held by clkmgr bit", {31'h0, core_rst_n}, 0);
    rd(12'h040, r); check("R2 readback 1", r, 32'h1);
    wr(12'h040, 32'h7);
    check("R2 ce_n", {31'h0, ce_n}, 1);
    rd(12'h040, r); check("R2 readback 7", r, 32'h7);
    wr(12'h040, 32'hFFFF_FFF8);
    rd(12'h040, r); check("R2 upper bits ignored", r, 0);

    // R10 disabled core still accessible
    wr(12'h040, 32'h3);
    wr(12'h040, 32'h0);
    check("R10 core off", {31'h0, core_rst_n}, 0);
    check("R10 clkmgr off", {31'h0, clkmgr_rst_n}, 0);
    wr(12'h444, 32'hCAFE_0123); model_write(12'h444, 32'hCAFE_0123);
    rd(12'h444, r); check("R10 channel rw while disabled", r, 32'hCAFE_0123);
    wr(12'h048, 32'h10);
    rd(12'h048, r); check("R10 mode rw while disabled", r, 32'h10);

    // R4 sync pulse
    @(negedge clk);
    wr_en = 1; wr_addr = 12'h044; wr_data = 32'h1;
    @(negedge clk); wr_en = 0;
    check("R4 pulse high", {31'h0, sync_pulse}, 1);
    @(negedge clk);
    check("R4 pulse one cycle", {31'h0, sync_pulse}, 0);
    wr(12'h044, 32'hFFFF_FFFE);
    check("R4 no pulse bit0 clear", {31'h0, sync_pulse}, 0);
    rd(12'h044, r); check("R4 reads zero", r, 0);

    // R5 routing mode
    wr(12'h048, 32'hFFFF_FFFF);
    check("R5 route set", {31'h0, indep_route}, 1);
    rd(12'h048, r); check("R5 readback", r, 32'h10);
    wr(12'h048, 32'hFFFF_FFEF);
    check("R5 route clear", {31'h0, indep_route}, 0);

    // R8 directed: last channel, every field
    wr(12'h4C0, 32'h1234_ABCD); model_write(12'h4C0, 32'h1234_ABCD);
    wr(12'h4C8, 32'h0000_8001); model_write(12'h4C8, 32'h0000_8001);
    wr(12'h4C4, 32'hFFFF_0001); model_write(12'h4C4, 32'hFFFF_0001);
    wr(12'h4CC, 32'h8000_7FFF); model_write(12'h4CC, 32'h8000_7FFF);
    wr(12'h4D8, 32'hFFFF_FFF2); model_write(12'h4D8, 32'hFFFF_FFF2);
    check_outs("R8 channel 3 fields");
    rd(12'h4C0, r); check("R8 scale A readback", r, 32'h0000_ABCD);
    rd(12'h4D8, r); check("R8 select readback", r, 32'h2);

    // R9 unmapped directed
    wr(12'h500, 32'hDEAD_BEEF);
    wr(12'h401, 32'hDEAD_BEEF);
    wr(12'h804, 32'hDEAD_BEEF);
    check_outs("R9 writes ignored");
    rd(12'h500, r); check("R9 slot beyond NUM_CH", r, 0);
    rd(12'h4C1, r); check("R9 misaligned", r, 0);
    rd(12'h4C4 | 12'h800, r); check("R9 above window", r, 0);

    // R11 read hold
    rd(12'h4C4, r);
    @(negedge clk); rd_addr = 12'h00C;
    @(negedge clk);
    check("R11 hold without rd_en", rd_data, 32'hFFFF_0001);

    // R8/R9 random
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a = rand_addr();
      if ($urandom % 2) begin
        logic [31:0] d = $urandom;
        wr(a, d); model_write(a, d);
        if (i % 20 == 0) check_outs("R8 R9 random outs");
      end else begin
        rd(a, r); check("R8 R9 random read", r, exp_read(a));
      end
    end
    check_outs("R8 final outs");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule